// File: doc/BRIEF.md
# Periodic and One-Shot Countdown Timer

This block is a down-counting timer for a larger control subsystem. It holds a limit (reload) value, a current count and a period. The period is the number of `tick_en` pulses that make up one count interval. Software drives it through single-cycle command strobes:

- start in periodic mode;
- start in one-shot mode;
- halt;
- write the count;
- write the limit, optionally copying it into the count;
- write the period.

When the count runs down to zero, the block raises a registered one-cycle interrupt pulse. In periodic mode it then reloads from the limit. In one-shot mode it falls back to the idle state.

Guards keep the timer from spinning without purpose. A zero period refuses a start and stops a running timer. A zero limit at periodic reload stops it too. The remaining count can always be read. It never shows a value past zero.

When several strobes arrive in one cycle, only one of them acts. The order is, from highest: halt, period write, limit write, count write, start, then the interval step.

Top module: `cdt_timer`

## Requirements
- R1: `mode_o` uses 0 = idle, 1 = periodic, 2 = one-shot and never shows 3. After reset, `mode_o` is 0, `count_o` is 0 and `irq_o` is 0.
- R2: While running, `count_o` drops by exactly one after every PERIOD cycles in which `tick_en` is high. Cycles with `tick_en` low change nothing.
- R3: An interval step that takes the count from 1 to 0 produces a one-cycle `irq_o` pulse in the next cycle. In periodic mode, the count is reloaded from the limit in that same cycle.
- R4: After a one-shot expiry, `mode_o` is 0 and `count_o` reads 0. Further ticks leave both unchanged.
- R5: A start request has the following effects:
  - It is refused, leaving `mode_o` at 0, when the period is 0.
  - It is refused when both the count and the limit are 0.
  - It is ignored when the timer already runs; mode and count do not change.
  - A start with count 0 loads the limit.
- R6: A halt sets `mode_o` to 0 and freezes `count_o`. Ticks do not change the count while halted. A later start resumes from the frozen count.
- R7: A limit write with `limit_reload`=1 also copies the value into the count and restarts the interval. With `limit_reload`=0 the count is unchanged.
- R8: A count write while running restarts the interval from the new value. Writing 0 while running acts as an immediate expiry.
- R9: A period write (`wr_data` low PER_W bits) restarts the interval. Writing 0 while running sets `mode_o` to 0 and keeps the count.
- R10: A periodic expiry with a limit of 0 sets `mode_o` to 0 with `count_o` 0.
- R11: While `mode_o` is nonzero, `count_o` is never 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | One pulse per prescaler tick |
| run_periodic | input | 1 | Start strobe, periodic mode |
| run_oneshot | input | 1 | Start strobe, one-shot mode |
| stop | input | 1 | Halt strobe |
| set_count | input | 1 | Count write strobe |
| set_limit | input | 1 | Limit write strobe |
| limit_reload | input | 1 | With set_limit, also copy into the count |
| set_period | input | 1 | Period write strobe |
| wr_data | input | CNT_W | Write value for the count, limit or period |
| count_o | output | CNT_W | Remaining count |
| mode_o | output | 2 | Run state |
| irq_o | output | 1 | One-cycle expiry pulse |

## Verification
The assertions assume that at most one command strobe is high in any cycle. Their antecedents name a single strobe with all others low, so the priority order never enters a property. The bench issues every command alone, in its own cycle, with `tick_en` low. Ticks are applied only in cycles free of commands. Each expected count therefore follows from the number of ticks applied and the programmed period.

// File: rtl/cdt_pkg.sv
package cdt_pkg;
  typedef enum logic [1:0] {
    MODE_IDLE     = 2'd0,
    MODE_PERIODIC = 2'd1,
    MODE_ONESHOT  = 2'd2
  } cdt_mode_e;
endpackage

// File: rtl/cdt_prescale.sv
module cdt_prescale #(
  parameter int PER_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             run,
  input  logic             tick_en,
  input  logic [PER_W-1:0] period,
  output logic             step
);
  logic [PER_W-1:0] pre_q;
  logic             last;

  assign last = (pre_q == period - PER_W'(1));
  assign step = run & tick_en & last;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      pre_q <= '0;
    end else if (run && tick_en) begin
      pre_q <= last ? '0 : pre_q + PER_W'(1);
    end
  end
endmodule

// File: rtl/cdt_core.sv
module cdt_core
  import cdt_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int PER_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step,
  input  logic             run_periodic,
  input  logic             run_oneshot,
  input  logic             stop,
  input  logic             set_count,
  input  logic             set_limit,
  input  logic             limit_reload,
  input  logic             set_period,
  input  logic [CNT_W-1:0] wr_data,
  output logic             restart,
  output logic [PER_W-1:0] period_o,
  output logic [CNT_W-1:0] count_o,
  output cdt_mode_e        mode_o,
  output logic             irq_o
);
  cdt_mode_e        mode_q, mode_n;
  logic [CNT_W-1:0] cnt_q, cnt_n, lim_q, lim_n;
  logic [PER_W-1:0] per_q, per_n;
  logic             irq_n, expire, running;

  assign running = (mode_q != MODE_IDLE);

  always_comb begin
    mode_n  = mode_q;
    cnt_n   = cnt_q;
    lim_n   = lim_q;
    per_n   = per_q;
    irq_n   = 1'b0;
    restart = 1'b0;
    expire  = 1'b0;
    if (stop) begin
      mode_n = MODE_IDLE;
    end else if (set_period) begin
      per_n   = wr_data[PER_W-1:0];
      restart = 1'b1;
      if (running && wr_data[PER_W-1:0] == '0) mode_n = MODE_IDLE;
    end else if (set_limit) begin
      lim_n = wr_data;
      if (limit_reload) begin
        cnt_n   = wr_data;
        restart = 1'b1;
        if (running && wr_data == '0) expire = 1'b1;
      end
    end else if (set_count) begin
      cnt_n   = wr_data;
      restart = 1'b1;
      if (running && wr_data == '0) expire = 1'b1;
    end else if (run_periodic || run_oneshot) begin
      if (!running && per_q != '0 && !(cnt_q == '0 && lim_q == '0)) begin
        mode_n  = run_periodic ? MODE_PERIODIC : MODE_ONESHOT;
        restart = 1'b1;
        if (cnt_q == '0) cnt_n = lim_q;
      end
    end else if (step && running) begin
      if (cnt_q <= CNT_W'(1)) expire = 1'b1;
      else                    cnt_n = cnt_q - CNT_W'(1);
    end

    if (expire) begin
      irq_n = 1'b1;
      if (mode_q == MODE_PERIODIC && lim_n != '0) begin
        cnt_n = lim_n;
      end else begin
        mode_n = MODE_IDLE;
        cnt_n  = '0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= MODE_IDLE;
      cnt_q  <= '0;
      lim_q  <= '0;
      per_q  <= '0;
      irq_o  <= 1'b0;
    end else begin
      mode_q <= mode_n;
      cnt_q  <= cnt_n;
      lim_q  <= lim_n;
      per_q  <= per_n;
      irq_o  <= irq_n;
    end
  end

  assign count_o  = cnt_q;
  assign mode_o   = mode_q;
  assign period_o = per_q;
endmodule

// File: rtl/cdt_timer.sv
module cdt_timer
  import cdt_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int PER_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_en,
  input  logic             run_periodic,
  input  logic             run_oneshot,
  input  logic             stop,
  input  logic             set_count,
  input  logic             set_limit,
  input  logic             limit_reload,
  input  logic             set_period,
  input  logic [CNT_W-1:0] wr_data,
  output logic [CNT_W-1:0] count_o,
  output logic [1:0]       mode_o,
  output logic             irq_o
);
  logic             step, restart;
  logic [PER_W-1:0] period;
  cdt_mode_e        mode;

  cdt_prescale #(.PER_W(PER_W)) u_pre (
    .clk(clk), .rst(rst), .clr(restart), .run(mode != MODE_IDLE),
    .tick_en(tick_en), .period(period), .step(step)
  );

  cdt_core #(.CNT_W(CNT_W), .PER_W(PER_W)) u_core (
    .clk(clk), .rst(rst), .step(step),
    .run_periodic(run_periodic), .run_oneshot(run_oneshot), .stop(stop),
    .set_count(set_count), .set_limit(set_limit), .limit_reload(limit_reload),
    .set_period(set_period), .wr_data(wr_data), .restart(restart),
    .period_o(period), .count_o(count_o), .mode_o(mode), .irq_o(irq_o)
  );

  assign mode_o = mode;
endmodule

// File: rtl/cdt_timer_chk.sv
module cdt_timer_chk #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             run_periodic,
  input logic             run_oneshot,
  input logic             stop,
  input logic             set_count,
  input logic             set_limit,
  input logic             limit_reload,
  input logic             set_period,
  input logic [CNT_W-1:0] count_o,
  input logic [1:0]       mode_o,
  input logic             irq_o
);
  logic past_ok;
  logic any_cmd;
  logic [2:0] ncmd;

  assign ncmd = 3'($countones({run_periodic, run_oneshot, stop, set_count,
                               set_limit, set_period}));
  assign any_cmd = (ncmd != 3'd0);

  always_ff @(posedge clk) begin
    if (rst) past_ok <= 1'b0;
    else     past_ok <= 1'b1;
  end

  // R1
  mode_enc_chk: assert property (@(posedge clk) disable iff (rst)
    mode_o != 2'd3);

  // R11
  run_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_o != 2'd0) |-> (count_o != '0));

  // R6
  stop_freeze_chk: assert property (@(posedge clk) disable iff (rst)
    (stop && ncmd == 3'd1) |=> (mode_o == 2'd0 && count_o == $past(count_o)));

  // R4
  oneshot_end_chk: assert property (@(posedge clk) disable iff (rst)
    (past_ok && irq_o && $past(mode_o) == 2'd2) |-> (mode_o == 2'd0 && count_o == '0));

  // R5
  run_ignore_chk: assert property (@(posedge clk) disable iff (rst)
    ((run_periodic || run_oneshot) && ncmd == 3'd1 && mode_o != 2'd0)
      |=> ($stable(mode_o) && $stable(count_o)));

  // R7
  limit_noreload_chk: assert property (@(posedge clk) disable iff (rst)
    (set_limit && !limit_reload && ncmd == 3'd1) |=> $stable(count_o));

  // R2
  step_bound_chk: assert property (@(posedge clk) disable iff (rst)
    (past_ok && !$past(any_cmd) && !irq_o)
      |-> (count_o == $past(count_o) || count_o == $past(count_o) - CNT_W'(1)));
endmodule

bind cdt_timer cdt_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .run_periodic(run_periodic), .run_oneshot(run_oneshot),
  .stop(stop), .set_count(set_count), .set_limit(set_limit),
  .limit_reload(limit_reload), .set_period(set_period),
  .count_o(count_o), .mode_o(mode_o), .irq_o(irq_o)
);

// File: tb/cdt_timer_bench.sv
module cdt_timer_bench;
  localparam int CNT_W = 32;
  localparam int OP_RUNP = 0, OP_RUNO = 1, OP_STOP = 2, OP_CNT = 3,
                 OP_LIM = 4, OP_PER = 5;

  logic clk = 1'b0, rst = 1'b1, tick_en = 1'b0;
  logic run_periodic = 0, run_oneshot = 0, stop = 0, set_count = 0;
  logic set_limit = 0, limit_reload = 0, set_period = 0;
  logic [CNT_W-1:0] wr_data = '0;
  logic [CNT_W-1:0] count_o;
  logic [1:0] mode_o;
  logic irq_o;
  int checks = 0, fails = 0;

  always #2 clk = ~clk;

  cdt_timer #(.CNT_W(CNT_W), .PER_W(16)) u_cdt_timer (
    .clk(clk), .rst(rst), .tick_en(tick_en), .run_periodic(run_periodic),
    .run_oneshot(run_oneshot), .stop(stop), .set_count(set_count),
    .set_limit(set_limit), .limit_reload(limit_reload), .set_period(set_period),
    .wr_data(wr_data), .count_o(count_o), .mode_o(mode_o), .irq_o(irq_o)
  );

  task automatic check(input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic cmd(input int op, input logic [CNT_W-1:0] d, input logic rl);
    wr_data = d;
    limit_reload = rl;
    case (op)
      OP_RUNP: run_periodic = 1'b1;
      OP_RUNO: run_oneshot  = 1'b1;
      OP_STOP: stop         = 1'b1;
      OP_CNT:  set_count    = 1'b1;
      OP_LIM:  set_limit    = 1'b1;
      default: set_period   = 1'b1;
    endcase
    @(posedge clk);
    @(negedge clk);
    {run_periodic, run_oneshot, stop, set_count, set_limit, set_period, limit_reload} = '0;
  endtask

  task automatic tick(input int n, output int irqs);
    irqs = 0;
    for (int i = 0; i < n; i++) begin
      tick_en = 1'b1;
      @(posedge clk);
      @(negedge clk);
      tick_en = 1'b0;
      if (irq_o) irqs++;
    end
  endtask

  task automatic t_reset();
    check("R1", "reset count", count_o, 0);
    check("R1", "reset mode", mode_o, 0);
    check("R1", "reset irq", irq_o, 0);
  endtask

  task automatic t_zero_period();
    cmd(OP_LIM, 32'd3, 1'b1);
    cmd(OP_RUNP, 0, 1'b0);
    check("R5", "start with zero period", mode_o, 0);
  endtask

  task automatic t_periodic();
    int n;
    cmd(OP_PER, 32'd2, 1'b0);
    check("R7", "reload copied limit", count_o, 3);
    cmd(OP_RUNP, 0, 1'b0);
    check("R1", "periodic mode", mode_o, 1);
    tick(2, n);
    check("R2", "one step per two ticks", count_o, 2);
    @(negedge clk); @(negedge clk);
    check("R2", "idle cycles hold count", count_o, 2);
    tick(4, n);
    check("R3", "irq pulses", n, 1);
    check("R3", "irq on last tick", irq_o, 1);
    check("R3", "periodic reload", count_o, 3);
    @(negedge clk);
    check("R3", "irq one cycle", irq_o, 0);
    check("R11", "running nonzero", count_o != 0, 1);
  endtask

  task automatic t_run_ignored();
    cmd(OP_RUNO, 0, 1'b0);
    check("R5", "start while running ignored", mode_o, 1);
  endtask

  task automatic t_stop_resume();
    int n;
    tick(1, n);
    cmd(OP_STOP, 0, 1'b0);
    check("R6", "halt mode", mode_o, 0);
    check("R6", "halt count", count_o, 3);
    tick(3, n);
    check("R6", "frozen under ticks", count_o, 3);
    cmd(OP_RUNO, 0, 1'b0);
    check("R6", "resume count", count_o, 3);
    check("R1", "one-shot mode", mode_o, 2);
    tick(6, n);
    check("R4", "one-shot irq", n, 1);
    check("R4", "one-shot idle", mode_o, 0);
    check("R4", "one-shot count zero", count_o, 0);
    tick(2, n);
    check("R4", "stays at zero", count_o, 0);
  endtask

  task automatic t_limit_noreload();
    cmd(OP_LIM, 32'd5, 1'b0);
    check("R7", "no-reload keeps count", count_o, 0);
    cmd(OP_RUNP, 0, 1'b0);
    check("R5", "start loads limit", count_o, 5);
  endtask

  task automatic t_count_write();
    int n;
    tick(1, n);
    cmd(OP_CNT, 32'd1, 1'b0);
    check("R8", "count written", count_o, 1);
    tick(1, n);
    check("R8", "interval restarted", count_o, 1);
    tick(1, n);
    check("R8", "expiry after full interval", n, 1);
    check("R3", "reload after count write", count_o, 5);
  endtask

  task automatic t_limit_reload_run();
    int n;
    cmd(OP_LIM, 32'd4, 1'b1);
    check("R7", "reload while running", count_o, 4);
    tick(2, n);
    check("R7", "count after reload", count_o, 3);
  endtask

  task automatic t_period_zero_run();
    cmd(OP_PER, 32'd0, 1'b0);
    check("R9", "zero period stops", mode_o, 0);
    check("R9", "count kept", count_o, 3);
  endtask

  task automatic t_zero_limit_expiry();
    int n;
    cmd(OP_PER, 32'd1, 1'b0);
    cmd(OP_LIM, 32'd0, 1'b0);
    cmd(OP_RUNP, 0, 1'b0);
    check("R9", "period one start", mode_o, 1);
    tick(3, n);
    check("R10", "irq", n, 1);
    check("R10", "zero limit idle", mode_o, 0);
    check("R10", "zero limit count", count_o, 0);
    cmd(OP_RUNP, 0, 1'b0);
    check("R5", "start with count and limit zero", mode_o, 0);
  endtask

  task automatic t_count_zero_run();
    cmd(OP_LIM, 32'd7, 1'b0);
    cmd(OP_RUNP, 0, 1'b0);
    check("R5", "loaded limit", count_o, 7);
    cmd(OP_CNT, 32'd0, 1'b0);
    check("R8", "zero write irq", irq_o, 1);
    check("R8", "zero write reload", count_o, 7);
    check("R11", "still running", mode_o, 1);
  endtask

  initial begin
    #200000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails + 0);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_zero_period();
    t_periodic();
    t_run_ignored();
    t_stop_resume();
    t_limit_noreload();
    t_count_write();
    t_limit_reload_run();
    t_period_zero_run();
    t_zero_limit_expiry();
    t_count_zero_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule